// File: doc/BRIEF.md
# Per-Set Recency Order Keeper

This block tracks recency for the replacement logic of a set-associative cache. For every set it holds an ordered list of way numbers. Position 0 holds the least recently used way and the highest occupied position holds the most recently used one. Next to each list it keeps a count of how many ways of that set have been handed out so far. Tags, data and dirty bits stay in the cache controller; this block only decides which way to use and records recency.

The controller sends one command at a time: a touch when a lookup hits, a fill when a line must be brought in, or a query to learn which way a fill would pick without changing anything. A set that is not yet full hands out its ways in strict ascending order. A full set gives up the way at the head of its list. The response names the chosen way and raises a victim flag when that way held a line before, which tells the controller to inspect the dirty bit of that way. A touch that names a way the set has not yet handed out is refused with an error flag.

Every command is accepted on one cycle, occupies the block for exactly one further cycle while the reordered list is written back, and produces a one-cycle response in the cycle after that.

Top module: `lru_order_list`

## Requirements
- R1: After synchronous reset every set is empty: `busy` and `resp_valid` are 0, and a query to any set returns way 0 with `resp_victim` = 0.
- R2: A command is taken on a rising edge where `cmd_valid` = 1 and `busy` = 0. `busy` is then 1 for exactly one cycle, and `resp_valid` is 1 for exactly the one cycle after it. A command offered while `busy` = 1 is ignored and has no effect on any set.
- R3: The `cmd_op` encoding is 2'b00 query, 2'b01 touch, 2'b10 fill; 2'b11 behaves exactly as a query.
- R4: A fill into a set holding k < NUM_WAYS ways returns way k with `resp_victim` = 0, appends way k as most recent, and raises the count to k+1, so a fresh set hands out ways 0, 1, 2, ... in order.
- R5: A fill into a full set returns the least recent way with `resp_victim` = 1. That way becomes most recent and the relative order of the other ways is kept.
- R6: A touch of a way held by the set returns that way with `resp_err` = 0. The way becomes most recent and the relative order of the other ways is kept.
- R7: A touch of a way not yet handed out by the set (including any touch of an empty set) returns the named way with `resp_err` = 1 and leaves that set's list and count unchanged.
- R8: A query returns the way a fill would choose at that moment and its victim flag (`resp_err` = 0) and changes no state.
- R9: Commands to one set never change the list or count of another set.
- R10: In a full 4-way set ordered 3,0,2,1 (least to most recent), a touch of way 0 leaves the order 3,2,1,0. A fill instead evicts way 3 and leaves 0,2,1,3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | Operation: 00 query, 01 touch, 10 fill, 11 query |
| cmd_set | input | SET_W | Set index addressed by the command |
| cmd_way | input | WAY_W | Way named by a touch; unused otherwise |
| busy | output | 1 | High while a taken command is being written back |
| resp_valid | output | 1 | One-cycle pulse carrying the response |
| resp_way | output | WAY_W | Chosen way (fill, query) or the named way (touch) |
| resp_victim | output | 1 | Chosen way held a line before (set was full) |
| resp_err | output | 1 | Touch named a way the set does not hold |

## Verification
The bench drives a set to the 3,0,2,1 order and checks that both a touch and a fill reorder it correctly. A design that shifted the wrong span, or wrote the moved way at position N-1 instead of count-1, would hand back the wrong victims on the fills that follow. Touches of unfilled ways and of empty sets are checked to leave the count alone. A design that appended on a refused touch would return the wrong way on the next fill or query. A command offered during the busy cycle must leave no trace, and a 2'b11 opcode must leave no trace either. A long mixed run over many sets is compared against a queue-based model on every clock, which exposes cross-set corruption and wrong response timing.

// File: rtl/lru_order_pkg.sv
package lru_order_pkg;

    // Command opcodes as seen on cmd_op.
    typedef enum logic [1:0] {
        OP_QUERY = 2'b00,
        OP_TOUCH = 2'b01,
        OP_FILL  = 2'b10,
        OP_ALIAS = 2'b11
    } lru_op_e;

    // Fold the spare code onto query so only three behaviours exist.
    function automatic lru_op_e decode_op(input logic [1:0] raw);
        lru_op_e op;
        op = lru_op_e'(raw);
        if (op == OP_ALIAS) begin
            op = OP_QUERY;
        end
        return op;
    endfunction

endpackage

// File: rtl/lru_set_store.sv
module lru_set_store #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int CNT_W = $clog2(NUM_WAYS + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [SET_W-1:0]                 rd_set,
    output logic [NUM_WAYS-1:0][WAY_W-1:0]   rd_list,
    output logic [CNT_W-1:0]                 rd_cnt,
    input  logic                             wr_en,
    input  logic [SET_W-1:0]                 wr_set,
    input  logic [NUM_WAYS-1:0][WAY_W-1:0]   wr_list,
    input  logic [CNT_W-1:0]                 wr_cnt
);

    logic [NUM_WAYS-1:0][WAY_W-1:0] list_mem [NUM_SETS];
    logic [CNT_W-1:0]               cnt_mem  [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                list_mem[s] <= '0;
                cnt_mem[s]  <= '0;
            end
        end else if (wr_en) begin
            list_mem[wr_set] <= wr_list;
            cnt_mem[wr_set]  <= wr_cnt;
        end
    end

    assign rd_list = list_mem[rd_set];
    assign rd_cnt  = cnt_mem[rd_set];

    // R4: a write-back either keeps the count or raises it by one.
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((wr_cnt == cnt_mem[wr_set]) ||
                   (wr_cnt == cnt_mem[wr_set] + 1'b1)));

    // R4: the count never passes the number of ways.
    assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_cnt <= CNT_W'(NUM_WAYS)));

    // R5: a full set stays full after any write-back.
    assert_full_stays_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (cnt_mem[wr_set] == CNT_W'(NUM_WAYS))) |-> (wr_cnt == CNT_W'(NUM_WAYS)));

endmodule

// File: rtl/lru_list_update.sv
module lru_list_update
    import lru_order_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int CNT_W = $clog2(NUM_WAYS + 1)
) (
    input  lru_op_e                          op,
    input  logic [NUM_WAYS-1:0][WAY_W-1:0]   cur_list,
    input  logic [CNT_W-1:0]                 cur_cnt,
    input  logic [WAY_W-1:0]                 way,
    output logic [NUM_WAYS-1:0][WAY_W-1:0]   nxt_list,
    output logic [CNT_W-1:0]                 nxt_cnt,
    output logic                             wr_en,
    output logic [WAY_W-1:0]                 sel_way,
    output logic                             victim,
    output logic                             err
);

    logic             full;
    logic             hit;
    logic [WAY_W-1:0] hit_pos;
    logic             do_rot;
    logic [WAY_W-1:0] rot_pos;
    logic [WAY_W-1:0] rot_way;
    logic [CNT_W-1:0] last;
    logic [WAY_W-1:0] next_free;

    // Search only the occupied prefix of the list.
    always_comb begin
        hit     = 1'b0;
        hit_pos = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (!hit && (CNT_W'(i) < cur_cnt) && (cur_list[i] == way)) begin
                hit     = 1'b1;
                hit_pos = WAY_W'(i);
            end
        end
    end

    always_comb begin
        full      = (cur_cnt == CNT_W'(NUM_WAYS));
        next_free = cur_cnt[WAY_W-1:0];
        last      = cur_cnt - 1'b1;
        nxt_list  = cur_list;
        nxt_cnt   = cur_cnt;
        wr_en     = 1'b0;
        victim    = 1'b0;
        err       = 1'b0;
        sel_way   = way;
        do_rot    = 1'b0;
        rot_pos   = '0;
        rot_way   = way;

        case (op)
            OP_FILL: begin
                wr_en = 1'b1;
                if (full) begin
                    victim  = 1'b1;
                    sel_way = cur_list[0];
                    do_rot  = 1'b1;
                    rot_pos = '0;
                    rot_way = cur_list[0];
                end else begin
                    sel_way             = next_free;
                    nxt_list[next_free] = next_free;
                    nxt_cnt             = cur_cnt + 1'b1;
                end
            end
            OP_TOUCH: begin
                sel_way = way;
                if (hit) begin
                    wr_en   = 1'b1;
                    do_rot  = 1'b1;
                    rot_pos = hit_pos;
                    rot_way = way;
                end else begin
                    err = 1'b1;
                end
            end
            default: begin
                victim  = full;
                sel_way = full ? cur_list[0] : next_free;
            end
        endcase

        // Parallel shift: entries after rot_pos move one place toward
        // the head, the moved way lands at the last occupied position.
        if (do_rot) begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                if (WAY_W'(i) < rot_pos) begin
                    nxt_list[i] = cur_list[i];
                end else if (CNT_W'(i) < last) begin
                    nxt_list[i] = cur_list[(i + 1) % NUM_WAYS];
                end else if (CNT_W'(i) == last) begin
                    nxt_list[i] = rot_way;
                end
            end
        end
    end

endmodule

// File: rtl/lru_order_list.sv
module lru_order_list
    import lru_order_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int CNT_W = $clog2(NUM_WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [SET_W-1:0] cmd_set,
    input  logic [WAY_W-1:0] cmd_way,
    output logic             busy,
    output logic             resp_valid,
    output logic [WAY_W-1:0] resp_way,
    output logic             resp_victim,
    output logic             resp_err
);

    typedef struct packed {
        lru_op_e          op;
        logic [SET_W-1:0] set;
        logic [WAY_W-1:0] way;
    } cmd_t;

    typedef struct packed {
        logic [WAY_W-1:0] way;
        logic             victim;
        logic             err;
    } rsp_t;

    cmd_t cmd_q;
    rsp_t rsp_q;
    logic busy_q;
    logic rv_q;

    logic [NUM_WAYS-1:0][WAY_W-1:0] rd_list;
    logic [CNT_W-1:0]               rd_cnt;
    logic [NUM_WAYS-1:0][WAY_W-1:0] upd_list;
    logic [CNT_W-1:0]               upd_cnt;
    logic                           upd_wr;
    logic [WAY_W-1:0]               upd_way;
    logic                           upd_victim;
    logic                           upd_err;

    lru_set_store #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_set  (cmd_q.set),
        .rd_list (rd_list),
        .rd_cnt  (rd_cnt),
        .wr_en   (busy_q && upd_wr),
        .wr_set  (cmd_q.set),
        .wr_list (upd_list),
        .wr_cnt  (upd_cnt)
    );

    lru_list_update #(
        .NUM_WAYS (NUM_WAYS)
    ) u_update (
        .op       (cmd_q.op),
        .cur_list (rd_list),
        .cur_cnt  (rd_cnt),
        .way      (cmd_q.way),
        .nxt_list (upd_list),
        .nxt_cnt  (upd_cnt),
        .wr_en    (upd_wr),
        .sel_way  (upd_way),
        .victim   (upd_victim),
        .err      (upd_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rv_q   <= 1'b0;
            cmd_q  <= '0;
            rsp_q  <= '0;
        end else begin
            rv_q <= 1'b0;
            if (busy_q) begin
                busy_q <= 1'b0;
                rv_q   <= 1'b1;
                rsp_q  <= '{way: upd_way, victim: upd_victim, err: upd_err};
            end else if (cmd_valid) begin
                busy_q <= 1'b1;
                cmd_q  <= '{op: decode_op(cmd_op), set: cmd_set, way: cmd_way};
            end
        end
    end

    assign busy        = busy_q;
    assign resp_valid  = rv_q;
    assign resp_way    = rsp_q.way;
    assign resp_victim = rsp_q.victim;
    assign resp_err    = rsp_q.err;

    // R2: a taken command raises busy on the next cycle.
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> busy);

    // R2: busy lasts exactly one cycle.
    assert_busy_single_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R2: every response follows a busy cycle.
    assert_resp_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(busy));

    // R7: a refused touch never writes the set back.
    assert_err_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && upd_err) |-> !upd_wr);

    // R5: a victim is only reported for a set that was full.
    assert_victim_full_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && upd_victim) |-> (rd_cnt == CNT_W'(NUM_WAYS)));

endmodule

// File: tb/lru_order_list_tb.sv
module lru_order_list_tb;

    localparam int SETS  = 16;
    localparam int WAYS  = 4;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic [SET_W-1:0] cmd_set = '0;
    logic [WAY_W-1:0] cmd_way = '0;
    logic             busy;
    logic             resp_valid;
    logic [WAY_W-1:0] resp_way;
    logic             resp_victim;
    logic             resp_err;

    lru_order_list #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_set     (cmd_set),
        .cmd_way     (cmd_way),
        .busy        (busy),
        .resp_valid  (resp_valid),
        .resp_way    (resp_way),
        .resp_victim (resp_victim),
        .resp_err    (resp_err)
    );

    always #4 clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_tag = "R1";

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int mq [SETS][$];
    bit exp_busy = 1'b0;
    bit exp_rv   = 1'b0;
    int exp_way  = 0;
    bit exp_vic  = 1'b0;
    bit exp_err  = 1'b0;
    int pend_op, pend_set, pend_way;

    task automatic model_exec(input int op, input int s, input int w);
        int idx;
        exp_err = 1'b0;
        exp_vic = 1'b0;
        if (op == 2) begin
            if (mq[s].size() < WAYS) begin
                exp_way = mq[s].size();
                mq[s].push_back(exp_way);
            end else begin
                exp_way = mq[s].pop_front();
                exp_vic = 1'b1;
                mq[s].push_back(exp_way);
            end
        end else if (op == 1) begin
            idx = -1;
            for (int i = 0; i < mq[s].size(); i++)
                if (idx < 0 && mq[s][i] == w) idx = i;
            exp_way = w;
            if (idx < 0) begin
                exp_err = 1'b1;
            end else begin
                mq[s].delete(idx);
                mq[s].push_back(w);
            end
        end else begin
            if (mq[s].size() < WAYS) begin
                exp_way = mq[s].size();
            end else begin
                exp_way = mq[s][0];
                exp_vic = 1'b1;
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) mq[s].delete();
            exp_busy = 1'b0;
            exp_rv   = 1'b0;
        end else if (exp_busy) begin
            exp_busy = 1'b0;
            exp_rv   = 1'b1;
            model_exec(pend_op, pend_set, pend_way);
        end else begin
            exp_rv = 1'b0;
            if (cmd_valid) begin
                exp_busy = 1'b1;
                pend_op  = (cmd_op == 2'b11) ? 0 : int'(cmd_op);
                pend_set = int'(cmd_set);
                pend_way = int'(cmd_way);
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(busy == exp_busy, "R2", "busy", busy, exp_busy);
            check(resp_valid == exp_rv, "R2", "resp_valid", resp_valid, exp_rv);
            if (exp_rv && resp_valid) begin
                check(int'(resp_way) == exp_way, cur_tag, "model way", resp_way, exp_way);
                check(resp_victim == exp_vic, cur_tag, "model victim", resp_victim, exp_vic);
                check(resp_err == exp_err, cur_tag, "model err", resp_err, exp_err);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    int r_way;
    bit r_vic;
    bit r_err;

    task automatic issue(input int op, input int s, input int w, input bit poke);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_set   = SET_W'(s);
        cmd_way   = WAY_W'(w);
        @(negedge clk);
        if (poke) begin
            // Offer a fill to the same set while busy; it must be ignored.
            cmd_op  = 2'b10;
            cmd_way = WAY_W'(w + 1);
        end else begin
            cmd_valid = 1'b0;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        r_way = int'(resp_way);
        r_vic = resp_victim;
        r_err = resp_err;
    endtask

    task automatic expect_resp(input string tag, input int w, input bit v, input bit e);
        check(r_way == w, tag, "way", r_way, w);
        check(r_vic == v, tag, "victim", r_vic, v);
        check(r_err == e, tag, "err", r_err, e);
    endtask

    // Drive set s into the order 3,0,2,1.
    task automatic build_3021(input int s);
        for (int k = 0; k < 4; k++) issue(2, s, 0, 1'b0);
        issue(1, s, 0, 1'b0);
        issue(1, s, 2, 1'b0);
        issue(1, s, 1, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);

        cur_tag = "R1";
        issue(0, 0, 0, 1'b0); expect_resp("R1", 0, 0, 0);
        issue(0, 9, 3, 1'b0); expect_resp("R1", 0, 0, 0);

        cur_tag = "R4";
        for (int k = 0; k < 4; k++) begin
            issue(2, 0, 0, 1'b0);
            expect_resp("R4", k, 0, 0);
        end

        cur_tag = "R8";
        issue(0, 0, 0, 1'b0); expect_resp("R8", 0, 1, 0);
        issue(0, 0, 2, 1'b0); expect_resp("R8", 0, 1, 0);

        cur_tag = "R10";
        build_3021(0);
        issue(0, 0, 0, 1'b0); expect_resp("R10", 3, 1, 0);
        issue(1, 0, 0, 1'b0); expect_resp("R6", 0, 0, 0);
        // Order now 3,2,1,0: fills evict in that order.
        issue(2, 0, 0, 1'b0); expect_resp("R10", 3, 1, 0);
        issue(2, 0, 0, 1'b0); expect_resp("R10", 2, 1, 0);
        issue(2, 0, 0, 1'b0); expect_resp("R10", 1, 1, 0);
        issue(2, 0, 0, 1'b0); expect_resp("R10", 0, 1, 0);

        build_3021(1);
        cur_tag = "R3";
        issue(3, 1, 2, 1'b0); expect_resp("R3", 3, 1, 0);
        cur_tag = "R10";
        // Fill evicts 3, order 0,2,1,3.
        issue(2, 1, 0, 1'b0); expect_resp("R5", 3, 1, 0);
        issue(2, 1, 0, 1'b0); expect_resp("R10", 0, 1, 0);
        issue(2, 1, 0, 1'b0); expect_resp("R10", 2, 1, 0);
        issue(2, 1, 0, 1'b0); expect_resp("R10", 1, 1, 0);

        cur_tag = "R7";
        issue(2, 2, 0, 1'b0); expect_resp("R4", 0, 0, 0);
        issue(2, 2, 0, 1'b0); expect_resp("R4", 1, 0, 0);
        issue(1, 2, 3, 1'b0); expect_resp("R7", 3, 0, 1);
        issue(1, 2, 2, 1'b0); expect_resp("R7", 2, 0, 1);
        issue(0, 2, 0, 1'b0); expect_resp("R7", 2, 0, 0);
        issue(1, 3, 0, 1'b0); expect_resp("R7", 0, 0, 1);
        issue(0, 3, 0, 1'b0); expect_resp("R7", 0, 0, 0);
        issue(2, 2, 0, 1'b0); expect_resp("R7", 2, 0, 0);

        cur_tag = "R9";
        issue(0, 0, 0, 1'b0); expect_resp("R9", 3, 1, 0);
        issue(0, 5, 0, 1'b0); expect_resp("R9", 0, 0, 0);

        cur_tag = "R2";
        issue(2, 4, 0, 1'b1); expect_resp("R2", 0, 0, 0);
        issue(0, 4, 0, 1'b0); expect_resp("R2", 1, 0, 0);

        cur_tag = "R6";
        for (int n = 0; n < 600; n++) begin
            issue(int'($urandom % 4), int'($urandom % 6), int'($urandom % 4), 1'b0);
        end

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        check(1'b0, "R2", "watchdog expired", cycles, 50000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule